// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one 32-bit atomic memory operation at a time against a single-port synchronous memory. A requester presents a 32-bit instruction word in the R-type atomic layout. Alongside it come the address value (the contents of the rs1 register) and the operand value (the contents of the rs2 register). The unit reads the old word at that address and computes the combined value. It writes that value back to the same address in the very next cycle, then reports the old word as the destination register result. Nine operations are supported: add, swap, xor, or, and, and signed and unsigned minimum and maximum.

The memory port is shared with a second requester that issues plain reads and writes. While the read-write pair of an atomic operation is in flight, the unit refuses that second requester, so nothing can reach memory between the atomic read and the atomic write. A lock can therefore be taken by swapping in 1 and testing whether the returned value was nonzero. The acquire and release ordering bits are captured at acceptance and presented with the result.

The controller is a four-state machine. IDLE waits for a request. READ issues the memory read. WRITE issues the combined write. DONE presents the result for one cycle. The transitions are: accept (IDLE to READ, legal request), reject (IDLE to DONE, illegal request), fetch (READ to WRITE), store (WRITE to DONE) and retire (DONE to IDLE).

Top module: `amo_unit`

## Requirements
- R1: Instruction fields are taken from fixed positions: function code in bits 31:27, acquire in bit 26, release in bit 25, width code in bits 14:12, destination index in bits 11:7. The other bits are ignored.
- R2: A request is taken only when `req_ready` is high, which is in IDLE only. The read is issued with `mem_en`=1 and `mem_we`=0 at `req_addr` in the first cycle after acceptance. The write to the same address follows in the second cycle. `done` pulses in the third cycle.
- R3: Function codes 00000 add, 00100 xor, 01000 or and 01100 and write old OP operand, with add wrapping modulo 2^32.
- R4: Function codes 10000 and 10100 write the signed minimum and maximum of old and operand. Codes 11000 and 11100 write the unsigned minimum and maximum.
- R5: Function code 00001 (swap) writes the operand unchanged and returns the previous memory word.
- R6: In the DONE cycle `rd_data` equals the memory word read, `rd_idx` is the destination index, and `rd_we` is high. When the destination index is 0, `rd_we` stays low but the memory write still takes place.
- R7: `busy` is high in the read and write cycles. During those cycles `alt_grant` is low, and the second requester's inputs do not reach the memory port. Outside them, the second requester drives the memory port and is granted.
- R8: Any other function code, or a width code other than 3'b010, leads straight to DONE with `illegal` high. There is no memory access and `rd_we` stays low.
- R9: `aq_o` and `rl_o` show the acquire and release bits of the accepted instruction during the operation and in its DONE cycle.
- R10: After reset the unit is in IDLE: `req_ready` is high, and `busy`, `done`, `rd_we` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Atomic request present |
| req_instr | input | 32 | Atomic instruction word |
| req_addr | input | 32 | Target address (rs1 value) |
| req_opnd | input | 32 | Operand (rs2 value) |
| req_ready | output | 1 | Unit can accept a request |
| busy | output | 1 | Read-write pair in flight |
| done | output | 1 | Result cycle pulse |
| illegal | output | 1 | Request was rejected (with done) |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Old memory word |
| aq_o | output | 1 | Captured acquire bit |
| rl_o | output | 1 | Captured release bit |
| alt_valid | input | 1 | Second requester access |
| alt_we | input | 1 | Second requester write |
| alt_addr | input | 32 | Second requester address |
| alt_wdata | input | 32 | Second requester write data |
| alt_grant | output | 1 | Second requester access taken |
| alt_rdata | output | 32 | Read data, valid the cycle after a granted read |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |

## Verification
The in-line assertions check several properties on every cycle. A read is always followed by a write, and that write goes to the address just read. The second requester is never granted while busy. A rejected request never passes through the memory states. The ordering bits hold still while an operation is in flight. The arithmetic of each of the nine operations, including signed versus unsigned ordering at the sign boundary, can only be shown by the bench's scenarios. The same holds for the returned old value, destination-zero suppression and the final memory contents. The bench compares these against a reference memory it keeps itself.

// File: rtl/amo_pkg.sv
package amo_pkg;
    localparam int XLEN = 32;
    localparam int RIDX_W = 5;
    localparam logic [2:0] WIDTH_WORD = 3'b010;

    localparam logic [4:0] F5_ADD  = 5'b00000;
    localparam logic [4:0] F5_SWAP = 5'b00001;
    localparam logic [4:0] F5_XOR  = 5'b00100;
    localparam logic [4:0] F5_OR   = 5'b01000;
    localparam logic [4:0] F5_AND  = 5'b01100;
    localparam logic [4:0] F5_MIN  = 5'b10000;
    localparam logic [4:0] F5_MAX  = 5'b10100;
    localparam logic [4:0] F5_MINU = 5'b11000;
    localparam logic [4:0] F5_MAXU = 5'b11100;

    typedef enum logic [3:0] {
        OP_ADD, OP_SWAP, OP_XOR, OP_OR, OP_AND,
        OP_MIN, OP_MAX, OP_MINU, OP_MAXU, OP_BAD
    } amo_op_e;

    typedef enum logic [1:0] {
        S_IDLE, S_READ, S_WRITE, S_DONE
    } amo_state_e;

    typedef struct packed {
        amo_op_e           op;
        logic              bad;
        logic              aq;
        logic              rl;
        logic [RIDX_W-1:0] rd;
    } amo_dec_t;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [31:0] instr,
    output amo_dec_t    dec
);
    logic [4:0] f5;
    logic [2:0] f3;
    amo_op_e    op;

    assign f5 = instr[31:27];
    assign f3 = instr[14:12];

    always_comb begin
        unique case (f5)
            F5_ADD:  op = OP_ADD;
            F5_SWAP: op = OP_SWAP;
            F5_XOR:  op = OP_XOR;
            F5_OR:   op = OP_OR;
            F5_AND:  op = OP_AND;
            F5_MIN:  op = OP_MIN;
            F5_MAX:  op = OP_MAX;
            F5_MINU: op = OP_MINU;
            F5_MAXU: op = OP_MAXU;
            default: op = OP_BAD;
        endcase
    end

    always_comb begin
        dec.op  = op;
        dec.bad = (op == OP_BAD) || (f3 != WIDTH_WORD);
        dec.aq  = instr[26];
        dec.rl  = instr[25];
        dec.rd  = instr[11:7];
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int W = XLEN
) (
    input  amo_op_e      op,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] result
);
    logic s_lt;
    logic u_lt;

    assign s_lt = $signed(old_val) < $signed(opnd);
    assign u_lt = old_val < opnd;

    always_comb begin
        unique case (op)
            OP_ADD:  result = old_val + opnd;
            OP_SWAP: result = opnd;
            OP_XOR:  result = old_val ^ opnd;
            OP_OR:   result = old_val | opnd;
            OP_AND:  result = old_val & opnd;
            OP_MIN:  result = s_lt ? old_val : opnd;
            OP_MAX:  result = s_lt ? opnd : old_val;
            OP_MINU: result = u_lt ? old_val : opnd;
            OP_MAXU: result = u_lt ? opnd : old_val;
            default: result = old_val;
        endcase
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_instr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_opnd,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              rd_we,
    output logic [RIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              aq_o,
    output logic              rl_o,
    input  logic              alt_valid,
    input  logic              alt_we,
    input  logic [ADDR_W-1:0] alt_addr,
    input  logic [DATA_W-1:0] alt_wdata,
    output logic              alt_grant,
    output logic [DATA_W-1:0] alt_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    amo_state_e        state, state_nx;
    amo_dec_t          dec, dec_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] alu_res;
    logic              accept;

    amo_decode u_dec (
        .instr (req_instr),
        .dec   (dec)
    );

    amo_alu #(.W(DATA_W)) u_alu (
        .op      (dec_q.op),
        .old_val (mem_rdata),
        .opnd    (opnd_q),
        .result  (alu_res)
    );

    assign accept = req_valid && (state == S_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = dec.bad ? S_DONE : S_READ;
            S_READ:  state_nx = S_WRITE;
            S_WRITE: state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            dec_q  <= '{op: OP_ADD, bad: 1'b0, aq: 1'b0, rl: 1'b0, rd: '0};
            addr_q <= '0;
            opnd_q <= '0;
            old_q  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                dec_q  <= dec;
                addr_q <= req_addr;
                opnd_q <= req_opnd;
            end
            if (state == S_WRITE) old_q <= mem_rdata;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = alt_addr;
        mem_wdata = alt_wdata;
        alt_grant = 1'b0;
        unique case (state)
            S_IDLE: begin
                req_ready = 1'b1;
                alt_grant = alt_valid;
                mem_en    = alt_valid;
                mem_we    = alt_valid && alt_we;
            end
            S_READ: begin
                busy     = 1'b1;
                mem_en   = 1'b1;
                mem_addr = addr_q;
            end
            S_WRITE: begin
                busy      = 1'b1;
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = addr_q;
                mem_wdata = alu_res;
            end
            S_DONE: begin
                done      = 1'b1;
                alt_grant = alt_valid;
                mem_en    = alt_valid;
                mem_we    = alt_valid && alt_we;
            end
            default: ;
        endcase
    end

    assign illegal   = done && dec_q.bad;
    assign rd_we     = done && !dec_q.bad && (dec_q.rd != '0);
    assign rd_idx    = dec_q.rd;
    assign rd_data   = old_q;
    assign aq_o      = dec_q.aq;
    assign rl_o      = dec_q.rl;
    assign alt_rdata = mem_rdata;

    // R7: second requester locked out while the pair is in flight
    a_r7_no_alt_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !alt_grant);

    // R2: a read is always followed by the write
    a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ) |=> (state == S_WRITE) && mem_we);

    // R2: the write hits the address just read
    a_r2_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ) |=> (mem_addr == $past(mem_addr)) && !$past(mem_we));

    // R8: a rejected request never passes through the memory states
    a_r8_illegal_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($past(state) == S_IDLE));

    // R9: ordering bits hold still while in flight
    a_r9_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({aq_o, rl_o}));

    // R6: one destination write per operation
    a_r6_single_rd_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |=> !rd_we);
endmodule

// File: tb/amo_unit_bench.sv
`timescale 1ns/1ps
module amo_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_instr = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_opnd = '0;
    logic        req_ready, busy, done, illegal, rd_we, aq_o, rl_o;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic        alt_valid = 1'b0;
    logic        alt_we = 1'b0;
    logic [31:0] alt_addr = '0;
    logic [31:0] alt_wdata = '0;
    logic        alt_grant;
    logic [31:0] alt_rdata;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [16];
    logic [31:0] refm [16];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    amo_unit u_amo_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_instr(req_instr), .req_addr(req_addr), .req_opnd(req_opnd),
        .req_ready(req_ready), .busy(busy), .done(done), .illegal(illegal),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data), .aq_o(aq_o), .rl_o(rl_o),
        .alt_valid(alt_valid), .alt_we(alt_we), .alt_addr(alt_addr), .alt_wdata(alt_wdata),
        .alt_grant(alt_grant), .alt_rdata(alt_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[5:2]];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [4:0] f5, input logic [31:0] t,
                                          input logic [31:0] b);
        case (f5)
            5'b00000: return t + b;
            5'b00001: return b;
            5'b00100: return t ^ b;
            5'b01000: return t | b;
            5'b01100: return t & b;
            5'b10000: return ($signed(t) < $signed(b)) ? t : b;
            5'b10100: return ($signed(t) > $signed(b)) ? t : b;
            5'b11000: return (t < b) ? t : b;
            5'b11100: return (t > b) ? t : b;
            default:  return t;
        endcase
    endfunction

    function automatic bit legal_f5(input logic [4:0] f5);
        return f5 inside {5'b00000, 5'b00001, 5'b00100, 5'b01000, 5'b01100,
                          5'b10000, 5'b10100, 5'b11000, 5'b11100};
    endfunction

    function automatic logic [4:0] pick_f5(input int k);
        case (k % 9)
            0: return 5'b00000; 1: return 5'b00001; 2: return 5'b00100;
            3: return 5'b01000; 4: return 5'b01100; 5: return 5'b10000;
            6: return 5'b10100; 7: return 5'b11000; default: return 5'b11100;
        endcase
    endfunction

    task automatic run_amo(input logic [4:0] f5, input bit aq, input bit rl,
                           input logic [4:0] rd, input logic [2:0] f3,
                           input int widx, input logic [31:0] opnd, input bit poke);
        bit          ok;
        logic [31:0] t;
        logic [31:0] nv;
        ok = legal_f5(f5) && (f3 == 3'b010);
        t  = refm[widx];
        nv = model(f5, t, opnd);
        @(negedge clk);
        chk("R2 req_ready idle", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_instr = {f5, aq, rl, 5'd7, 5'd9, f3, rd, 7'b0101111};
        req_addr  = {26'b0, widx[3:0], 2'b00};
        req_opnd  = opnd;
        @(negedge clk);
        req_valid = 1'b0;
        req_instr = $urandom;
        if (ok) begin
            chk("R2 read enable", {30'b0, mem_en, mem_we}, 32'd2);
            chk("R2 read addr", mem_addr, {26'b0, widx[3:0], 2'b00});
            chk("R7 busy in read", {31'b0, busy}, 32'd1);
            chk("R9 ordering bits", {30'b0, aq_o, rl_o}, {30'b0, aq, rl});
            if (poke) begin
                alt_valid = 1'b1; alt_we = 1'b1;
                alt_addr = {26'b0, 4'(widx + 1), 2'b00}; alt_wdata = 32'hDEAD_BEEF;
                #0.1;
                chk("R7 no grant in read", {31'b0, alt_grant}, 32'd0);
                chk("R7 alt blocked read", {31'b0, mem_we}, 32'd0);
            end
            @(negedge clk);
            chk("R2 write enable", {30'b0, mem_en, mem_we}, 32'd3);
            chk("R2 write addr", mem_addr, {26'b0, widx[3:0], 2'b00});
            chk("R3 R4 R5 write data", mem_wdata, nv);
            if (poke) begin
                chk("R7 no grant in write", {31'b0, alt_grant}, 32'd0);
                alt_valid = 1'b0; alt_we = 1'b0;
            end
            @(negedge clk);
            refm[widx] = nv;
        end
        chk("R2 done pulse", {31'b0, done}, 32'd1);
        chk("R8 illegal flag", {31'b0, illegal}, {31'b0, !ok});
        chk("R6 rd write", {31'b0, rd_we}, {31'b0, ok && (rd != 0)});
        if (ok) begin
            chk("R6 rd data", rd_data, t);
            chk("R1 rd idx", {27'b0, rd_idx}, {27'b0, rd});
        end
        chk("R9 ordering at done", {30'b0, aq_o, rl_o}, {30'b0, aq, rl});
        chk("R6 R8 memory contents", mem[widx], refm[widx]);
        chk("R7 busy low at done", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin
            mem[i]  = 32'h1000_0000 * i + 32'h35 * i;
            refm[i] = 32'h1000_0000 * i + 32'h35 * i;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 ready", {31'b0, req_ready}, 32'd1);
        chk("R10 quiet", {28'b0, busy, done, rd_we, illegal}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 add wraps
        refm[1] = 32'hFFFF_FFFF; mem[1] = 32'hFFFF_FFFF;
        run_amo(5'b00000, 0, 0, 5'd3, 3'b010, 1, 32'd2, 0);
        // R5 lock acquire by swap, with second requester poking (R7)
        refm[2] = 32'd0; mem[2] = 32'd0;
        run_amo(5'b00001, 1, 0, 5'd5, 3'b010, 2, 32'd1, 1);
        run_amo(5'b00001, 1, 1, 5'd5, 3'b010, 2, 32'd1, 1);
        // R4 signed vs unsigned at sign boundary
        refm[3] = 32'h8000_0000; mem[3] = 32'h8000_0000;
        run_amo(5'b10000, 0, 1, 5'd4, 3'b010, 3, 32'd1, 0);
        refm[4] = 32'h8000_0000; mem[4] = 32'h8000_0000;
        run_amo(5'b11000, 0, 0, 5'd4, 3'b010, 4, 32'd1, 0);
        run_amo(5'b10100, 0, 0, 5'd6, 3'b010, 5, 32'hFFFF_FFF0, 0);
        run_amo(5'b11100, 0, 0, 5'd6, 3'b010, 6, 32'hFFFF_FFF0, 0);
        // R6 destination zero: memory still updated
        run_amo(5'b01000, 0, 0, 5'd0, 3'b010, 7, 32'h00F0_0F00, 0);
        // R8 illegal code and bad width
        run_amo(5'b00010, 0, 0, 5'd8, 3'b010, 8, 32'h1234_5678, 0);
        run_amo(5'b00000, 0, 0, 5'd8, 3'b011, 8, 32'h1234_5678, 0);
        // R7 second requester served when idle
        @(negedge clk);
        alt_valid = 1'b1; alt_we = 1'b1; alt_addr = 32'h24; alt_wdata = 32'hCAFE_0009;
        #0.1;
        chk("R7 grant idle", {31'b0, alt_grant}, 32'd1);
        @(negedge clk);
        alt_valid = 1'b0; alt_we = 1'b0;
        refm[9] = 32'hCAFE_0009;
        chk("R7 alt write landed", mem[9], refm[9]);
        // random mix, R1 R3 R4 R5
        for (int k = 0; k < 60; k++) begin
            logic [4:0] f5;
            int r;
            r  = $urandom_range(0, 11);
            f5 = (r < 10) ? pick_f5($urandom) : 5'($urandom);
            run_amo(f5, 1'($urandom), 1'($urandom), 5'($urandom), 
                    ($urandom_range(0, 7) == 0) ? 3'b110 : 3'b010,
                    $urandom_range(0, 15), $urandom, 1'($urandom));
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule